// File: doc/BRIEF.md
# PHY Management Register Responder

This block models the register file of an Ethernet PHY as software on the MAC side sees it. Software reaches it through two 32-bit words on a simple register bus: a command word and a data word. A command write names a PHY address, a PHY register index and a direction. If the address matches the configured PHY address, the responder carries out the access one clock later against its internal PHY registers. A read command leaves the PHY register value in the data word. A write command takes its value from the data word.

The model holds a writable control register and an advertisement register. It returns fixed values for the identifier and link-partner words. It reports a status word whose link bit tracks a live input. Nothing is serialised: there is no MDIO/MDC signalling, only the register-level behaviour.

On the bus, word slot 0 is the command word and slot 1 is the data word. Other slots read as zero and ignore writes. Reads are combinational from `busAddr`.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset the command word and the data word both read 0, and a read of any bus slot other than 0 or 1 returns 0.
- R2: In the command word, bits 15:12 hold the PHY address, bits 7:4 the PHY register index, bit 1 the direction (1 = write) and bit 0 a busy flag. The command word reads back as written, except that bit 0 always reads 0.
- R3: A command to the matching PHY address takes effect on the clock edge after the command write, so a data-word read in the next cycle returns the result.
- R4: A command whose PHY address (bits 15:12) differs from the `phyAddr` input leaves the data word and every PHY register unchanged.
- R5: After reset, PHY register 0 (control) reads 0x3100, register 4 (advertisement) reads 0, and register 1 (status) reads 0xFE28 with bit 2 added when `linkUp` is 1.
- R6: Status bit 2 equals the `linkUp` input at the time the read command executes.
- R7: Register 2 reads 0x0044, register 3 reads 0x1400 and register 5 reads 0x0DE0. Write commands to registers 2, 3 and 5 change none of them.
- R8: A write to register 0 with data bit 15 clear stores data bits 15:0 with bits 15 and 9 forced to 0.
- R9: A write to register 0 with data bit 15 set returns control to 0x3100 and advertisement to 0, while the status link bit keeps following `linkUp`.
- R10: A write to register 4 stores data bits 15:0, and a later read returns them zero-extended.
- R11: A read command to a register index above 5 sets the data word to 0.
- R12: Software can write the data word directly on slot 1 and read it back, and that value supplies the data for PHY write commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W (2) | Word slot: 0 command, 1 data |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for the slot on `busAddr` (combinational) |
| linkUp | input | 1 | Live link state reported in status bit 2 |
| phyAddr | input | 4 | PHY address this model answers to |

## Verification
A command written on one edge is held in the command word at that edge. It is executed on the following edge, so its effect on the data word or the PHY registers is due one cycle after the write cycle. The bench drives the bus on falling edges and reads combinationally a moment after a falling edge. Its first read after a command write therefore lands in the cycle right after the execute edge, and each check samples there. Direct data-word writes and command readback are due on the write edge itself, and are checked on the next falling edge.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;

  // command word field positions
  localparam int CMD_PHY_LSB  = 12;
  localparam int CMD_PHY_W    = 4;
  localparam int CMD_REG_LSB  = 4;
  localparam int CMD_REG_W    = 4;
  localparam int CMD_WR_BIT   = 1;
  localparam int CMD_BUSY_BIT = 0;

  // PHY register file
  localparam int PREG_W = 16;

  localparam logic [CMD_REG_W-1:0] IDX_CTRL  = 4'd0;
  localparam logic [CMD_REG_W-1:0] IDX_STAT  = 4'd1;
  localparam logic [CMD_REG_W-1:0] IDX_ID_HI = 4'd2;
  localparam logic [CMD_REG_W-1:0] IDX_ID_LO = 4'd3;
  localparam logic [CMD_REG_W-1:0] IDX_ADV   = 4'd4;
  localparam logic [CMD_REG_W-1:0] IDX_LPA   = 4'd5;

  localparam logic [PREG_W-1:0] CTRL_RST_VAL  = 16'h3100;
  localparam logic [PREG_W-1:0] CTRL_CLR_MASK = 16'h8200;
  localparam int                CTRL_RST_BIT  = 15;
  localparam logic [PREG_W-1:0] STAT_FIXED    = 16'hFE28;
  localparam int                STAT_LINK_BIT = 2;
  localparam logic [PREG_W-1:0] ID_HI_VAL     = 16'h0044;
  localparam logic [PREG_W-1:0] ID_LO_VAL     = 16'h1400;
  localparam logic [PREG_W-1:0] LPA_VAL       = 16'h0DE0;

  // strobes from control to datapath
  typedef struct packed {
    logic                 cmdLoad;
    logic                 dataLoad;
    logic                 execRead;
    logic                 execWrite;
    logic [CMD_REG_W-1:0] regIdx;
  } mgmt_strobe_t;

endpackage

// File: rtl/phymgmt_ctrl.sv
module phymgmt_ctrl
  import phymgmt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CMD_PHY_W-1:0] phyAddr,
  input  logic [CMD_PHY_W-1:0] cmdPhy,
  input  logic [CMD_REG_W-1:0] cmdIdx,
  input  logic                 cmdWr,
  output mgmt_strobe_t         strb
);

  localparam logic [ADDR_W-1:0] SLOT_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SLOT_DATA = ADDR_W'(1);

  logic pendQ;
  logic hit;

  // a command word written on this edge is executed on the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendQ <= 1'b0;
    else        pendQ <= busWrite && (busAddr == SLOT_CMD);
  end

  assign hit = pendQ && (cmdPhy == phyAddr);

  always_comb begin
    strb.cmdLoad   = busWrite && (busAddr == SLOT_CMD);
    strb.dataLoad  = busWrite && (busAddr == SLOT_DATA);
    strb.execRead  = hit && !cmdWr;
    strb.execWrite = hit && cmdWr;
    strb.regIdx    = cmdIdx;
  end

endmodule

// File: rtl/phymgmt_datapath.sv
module phymgmt_datapath
  import phymgmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mgmt_strobe_t      strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              linkUp,
  output logic [DATA_W-1:0] cmdWord,
  output logic [DATA_W-1:0] dataWord,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PAD_W = DATA_W - PREG_W;

  logic [DATA_W-1:0] cmdQ, dataQ;
  logic [PREG_W-1:0] ctrlQ, advQ;
  logic [PREG_W-1:0] statusVal;
  logic [PREG_W-1:0] phyRdVal;
  logic              phyRdValid;
  logic [PREG_W-1:0] wrVal;

  assign wrVal = dataQ[PREG_W-1:0];

  always_comb begin
    statusVal = STAT_FIXED;
    statusVal[STAT_LINK_BIT] = linkUp;
  end

  // PHY register read decode
  always_comb begin
    phyRdValid = 1'b1;
    unique case (strb.regIdx)
      IDX_CTRL:  phyRdVal = ctrlQ;
      IDX_STAT:  phyRdVal = statusVal;
      IDX_ID_HI: phyRdVal = ID_HI_VAL;
      IDX_ID_LO: phyRdVal = ID_LO_VAL;
      IDX_ADV:   phyRdVal = advQ;
      IDX_LPA:   phyRdVal = LPA_VAL;
      default: begin
        phyRdVal   = '0;
        phyRdValid = 1'b0;
      end
    endcase
  end

  // command word: busy flag never stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ <= '0;
    end else if (strb.cmdLoad) begin
      cmdQ <= busWdata;
      cmdQ[CMD_BUSY_BIT] <= 1'b0;
    end
  end

  // data word: an executing read wins over a direct write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ <= '0;
    end else if (strb.execRead) begin
      dataQ <= phyRdValid ? {{PAD_W{1'b0}}, phyRdVal} : '0;
    end else if (strb.dataLoad) begin
      dataQ <= busWdata;
    end
  end

  // writable PHY registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ <= CTRL_RST_VAL;
      advQ  <= '0;
    end else if (strb.execWrite) begin
      if (strb.regIdx == IDX_CTRL) begin
        if (wrVal[CTRL_RST_BIT]) begin
          ctrlQ <= CTRL_RST_VAL;
          advQ  <= '0;
        end else begin
          ctrlQ <= wrVal & ~CTRL_CLR_MASK;
        end
      end else if (strb.regIdx == IDX_ADV) begin
        advQ <= wrVal;
      end
    end
  end

  assign cmdWord  = cmdQ;
  assign dataWord = dataQ;

  always_comb begin
    if (busAddr == ADDR_W'(0))      busRdata = cmdQ;
    else if (busAddr == ADDR_W'(1)) busRdata = dataQ;
    else                            busRdata = '0;
  end

endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phymgmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              linkUp,
  input  logic [3:0]        phyAddr
);

  mgmt_strobe_t      strb;
  logic [DATA_W-1:0] cmdWord;
  logic [DATA_W-1:0] dataWord;

  phymgmt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .phyAddr (phyAddr),
    .cmdPhy  (cmdWord[CMD_PHY_LSB +: CMD_PHY_W]),
    .cmdIdx  (cmdWord[CMD_REG_LSB +: CMD_REG_W]),
    .cmdWr   (cmdWord[CMD_WR_BIT]),
    .strb    (strb)
  );

  phymgmt_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .linkUp  (linkUp),
    .cmdWord (cmdWord),
    .dataWord(dataWord),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/phy_mgmt_responder_chk.sv
module phy_mgmt_responder_chk
  import phymgmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        wrPhy,
  input logic              linkUp,
  input logic [3:0]        phyAddr,
  input logic [3:0]        cmdPhy,
  input logic              cmdBusy,
  input logic [DATA_W-1:0] dataWord,
  input logic              execRead,
  input logic              execWrite,
  input logic [3:0]        regIdx
);

  logic cmdWr;
  assign cmdWr = busWrite && (busAddr == ADDR_W'(0));

  p_busy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmdWr |=> (!cmdBusy && cmdPhy == $past(wrPhy)));

  p_exec_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWr && wrPhy == phyAddr) |=> (execRead || execWrite));

  p_single_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({execRead, execWrite}));

  p_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (execRead || execWrite) |-> (cmdPhy == phyAddr));

  p_link_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (execRead && regIdx == IDX_STAT) |=> (dataWord[STAT_LINK_BIT] == $past(linkUp)));

  p_unsup_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (execRead && regIdx > IDX_LPA) |=> (dataWord == '0));

endmodule

bind phy_mgmt_responder phy_mgmt_responder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .wrPhy    (busWdata[15:12]),
  .linkUp   (linkUp),
  .phyAddr  (phyAddr),
  .cmdPhy   (cmdWord[15:12]),
  .cmdBusy  (cmdWord[0]),
  .dataWord (dataWord),
  .execRead (strb.execRead),
  .execWrite(strb.execWrite),
  .regIdx   (strb.regIdx)
);

// File: tb/tb_phy_mgmt_responder.sv
module tb_phy_mgmt_responder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        linkUp = 1'b1;
  logic [3:0]  phyAddr = 4'd5;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_mgmt_responder dut (
    .clk(clk), .rst_n(rst_n), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .linkUp(linkUp), .phyAddr(phyAddr)
  );

  function automatic logic [31:0] mkCmd(input logic [3:0] pa, input logic [3:0] idx,
                                        input logic wr, input logic busy);
    return {16'h0, pa, 4'h0, idx, 2'b00, wr, busy};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  // read command, then the data word in the cycle after the execute edge
  task automatic phyRd(input logic [3:0] pa, input logic [3:0] idx, output logic [31:0] v);
    busWr(2'd0, mkCmd(pa, idx, 1'b0, 1'b0));
    busRd(2'd1, v);
  endtask

  task automatic phyWr(input logic [3:0] pa, input logic [3:0] idx, input logic [31:0] d);
    busWr(2'd1, d);
    busWr(2'd0, mkCmd(pa, idx, 1'b1, 1'b0));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    busRd(2'd0, v); chk("R1 cmd reset", v, 32'h0);
    busRd(2'd1, v); chk("R1 data reset", v, 32'h0);
    busRd(2'd2, v); chk("R1 unused slot", v, 32'h0);
  endtask

  task automatic t_cmd_readback;
    logic [31:0] v;
    busWr(2'd0, 32'h0000_3FF3);   // address 3: ignored by PHY 5
    busRd(2'd0, v); chk("R2 busy bit reads zero", v, 32'h0000_3FF2);
  endtask

  task automatic t_reset_values;
    logic [31:0] v;
    phyRd(4'd5, 4'd0, v); chk("R3 R5 control reset", v, 32'h3100);
    phyRd(4'd5, 4'd4, v); chk("R5 adv reset", v, 32'h0);
    phyRd(4'd5, 4'd1, v); chk("R5 status link up", v, 32'hFE2C);
  endtask

  task automatic t_link;
    logic [31:0] v;
    linkUp = 1'b0;
    phyRd(4'd5, 4'd1, v); chk("R6 status link down", v, 32'hFE28);
    linkUp = 1'b1;
    phyRd(4'd5, 4'd1, v); chk("R6 status link back", v, 32'hFE2C);
  endtask

  task automatic t_fixed;
    logic [31:0] v;
    phyRd(4'd5, 4'd2, v); chk("R7 id high", v, 32'h0044);
    phyRd(4'd5, 4'd3, v); chk("R7 id low", v, 32'h1400);
    phyRd(4'd5, 4'd5, v); chk("R7 link partner", v, 32'h0DE0);
    phyWr(4'd5, 4'd2, 32'hFFFF);
    phyWr(4'd5, 4'd5, 32'h0000);
    phyRd(4'd5, 4'd2, v); chk("R7 id write ignored", v, 32'h0044);
    phyRd(4'd5, 4'd5, v); chk("R7 lpa write ignored", v, 32'h0DE0);
  endtask

  task automatic t_data_reg;
    logic [31:0] v;
    busWr(2'd1, 32'h1234_5678);
    busRd(2'd1, v); chk("R12 data direct write", v, 32'h1234_5678);
  endtask

  task automatic t_ctrl_adv;
    logic [31:0] v;
    phyWr(4'd5, 4'd0, 32'h0000_7FFF);
    phyRd(4'd5, 4'd0, v); chk("R8 control masked store", v, 32'h7DFF);
    phyWr(4'd5, 4'd4, 32'hABCD_1234);
    phyRd(4'd5, 4'd4, v); chk("R10 R12 adv low half", v, 32'h1234);
    phyWr(4'd5, 4'd0, 32'h0000_8000);
    phyRd(4'd5, 4'd0, v); chk("R9 control soft reset", v, 32'h3100);
    phyRd(4'd5, 4'd4, v); chk("R9 adv cleared", v, 32'h0);
    phyRd(4'd5, 4'd1, v); chk("R9 link kept", v, 32'hFE2C);
  endtask

  task automatic t_mismatch;
    logic [31:0] v;
    busWr(2'd1, 32'hAAAA_5555);
    busWr(2'd0, mkCmd(4'd6, 4'd2, 1'b0, 1'b0));
    busRd(2'd1, v); chk("R4 foreign read no effect", v, 32'hAAAA_5555);
    busWr(2'd1, 32'h0000_0140);
    busWr(2'd0, mkCmd(4'd4, 4'd0, 1'b1, 1'b1));
    phyRd(4'd5, 4'd0, v); chk("R4 foreign write no effect", v, 32'h3100);
  endtask

  task automatic t_unsupported;
    logic [31:0] v;
    busWr(2'd1, 32'hFFFF_FFFF);
    phyRd(4'd5, 4'd9, v); chk("R11 unsupported read zero", v, 32'h0);
    busWr(2'd1, 32'hFFFF_FFFF);
    phyRd(4'd5, 4'd15, v); chk("R11 top index zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_readback();
    t_reset_values();
    t_link();
    t_fixed();
    t_data_reg();
    t_ctrl_adv();
    t_mismatch();
    t_unsupported();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule